// File: doc/BRIEF.md
# Port change interrupt detector

This block watches a vector of synchronized general-purpose port pins and drives an active-low interrupt request toward a host. The request goes low whenever the pins differ from a stored reference snapshot, in either direction and on any pin. It is released again either when the pins return to the snapshot or when the host accesses this device over the serial bus. At each such access, the current pin state becomes the new reference.

The serial bus controller supplies the access timing. It marks the acknowledge bit of a read or of a write addressed to this device, together with single-cycle strobes for the rising and falling edges of the serial clock. A read clears the request on the rising clock edge of its acknowledge bit. A write clears it on the falling edge of its acknowledge bit. Traffic for other devices, which the controller signals with the device-select input low, leaves the detector untouched. The output is modelled as the open-drain line level: 1 means released and 0 means pulled low.

Top module: `pin_change_irq`

## Requirements
- R1: After reset, int_n is 1. The reference is loaded from the pin state present on the first clock after reset, so a non-zero pin state at reset raises no request.
- R2: When the pins sampled at a clock edge differ from the reference in any bit, rising or falling, and no clear happens at that edge, int_n is 0 after that edge.
- R3: When the pins sampled at a clock edge equal the reference and no clear happens, int_n is 1 after that edge. A request therefore withdraws itself when the pins revert.
- R4: A read clear happens at an edge where dev_sel, rd_ack and scl_rise are all 1. After that edge int_n is 1, and the reference holds the pins sampled at that edge.
- R5: A write clear happens at an edge where dev_sel, wr_ack and scl_fall are all 1. After that edge int_n is 1, and the reference holds the pins sampled at that edge.
- R6: rd_ack together with scl_fall, or wr_ack together with scl_rise, clears nothing and leaves the reference unchanged.
- R7: While dev_sel is 0, rd_ack and wr_ack have no effect on int_n or on the reference.
- R8: After a clear, changes are detected against the newly captured reference, so a return to the old pin value raises the request.
- R9: A pin change in the same cycle as a clear is absorbed into the new reference and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins | input | PIN_W | Synchronized port pin levels |
| dev_sel | input | 1 | Current transfer is addressed to this device |
| rd_ack | input | 1 | Acknowledge bit of a read transfer is in progress |
| wr_ack | input | 1 | Acknowledge bit of a write transfer is in progress |
| scl_rise | input | 1 | Single-cycle strobe on the serial clock rising edge |
| scl_fall | input | 1 | Single-cycle strobe on the serial clock falling edge |
| int_n | output | 1 | Interrupt line level, 0 = request (drive low), 1 = released |

## Verification
The assertions assume that the controller never raises scl_rise and scl_fall in the same cycle, and never marks a read and a write acknowledge at once. The stimulus therefore pulses each strobe alone, for one cycle, and holds the acknowledge flags mutually exclusive. The pins are assumed already synchronized, so the bench changes them only on the falling clock edge. It deliberately stacks a pin change onto a clear cycle, so that the absorption case is checked against an exact cycle count.

// File: rtl/pci_pkg.sv
package pci_pkg;

  typedef enum logic [1:0] {
    CLR_NONE  = 2'd0,
    CLR_READ  = 2'd1,
    CLR_WRITE = 2'd2
  } clr_src_e;

  // Decide which access, if any, re-arms the detector this cycle.
  function automatic clr_src_e clear_source(input logic sel,
                                            input logic rd,
                                            input logic wr,
                                            input logic rise,
                                            input logic fall);
    clr_src_e s;
    s = CLR_NONE;
    if (sel && rd && rise)      s = CLR_READ;
    else if (sel && wr && fall) s = CLR_WRITE;
    return s;
  endfunction

  function automatic int grp_count(input int width, input int grp);
    return (width + grp - 1) / grp;
  endfunction

  function automatic int grp_hi(input int width, input int grp, input int idx);
    return ((idx + 1) * grp > width) ? width - 1 : (idx + 1) * grp - 1;
  endfunction

endpackage

// File: rtl/pci_clear_qual.sv
module pci_clear_qual
  import pci_pkg::*;
(
  input  logic     dev_sel,
  input  logic     rd_ack,
  input  logic     wr_ack,
  input  logic     scl_rise,
  input  logic     scl_fall,
  output clr_src_e clr_src,
  output logic     clr_evt
);
  always_comb begin
    clr_src = clear_source(dev_sel, rd_ack, wr_ack, scl_rise, scl_fall);
    clr_evt = (clr_src != CLR_NONE);
  end
endmodule

// File: rtl/pci_ref_store.sv
module pci_ref_store #(
  parameter int PIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pins,
  input  logic             clr_evt,
  output logic             armed,
  output logic [PIN_W-1:0] ref_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      ref_q <= '0;
    end else if (!armed) begin
      armed <= 1'b1;
      ref_q <= pins;
    end else if (clr_evt) begin
      ref_q <= pins;
    end
  end
endmodule

// File: rtl/pci_diff.sv
module pci_diff
  import pci_pkg::*;
#(
  parameter int PIN_W = 16,
  parameter int GRP_W = 8
) (
  input  logic [PIN_W-1:0] cur,
  input  logic [PIN_W-1:0] snap,
  output logic             any_diff
);
  localparam int NGRP = grp_count(PIN_W, GRP_W);

  logic [NGRP-1:0] grp_diff;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LO = g * GRP_W;
    localparam int HI = grp_hi(PIN_W, GRP_W, g);
    assign grp_diff[g] = |(cur[HI:LO] ^ snap[HI:LO]);
  end

  assign any_diff = |grp_diff;
endmodule

// File: rtl/pci_irq_out.sv
module pci_irq_out (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic clr_evt,
  input  logic any_diff,
  output logic int_n
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= armed && !clr_evt && any_diff;
  end

  assign int_n = !req_q;
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pci_pkg::*;
#(
  parameter int PIN_W = 16,
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pins,
  input  logic             dev_sel,
  input  logic             rd_ack,
  input  logic             wr_ack,
  input  logic             scl_rise,
  input  logic             scl_fall,
  output logic             int_n
);
  clr_src_e         clr_src;
  logic             clr_evt;
  logic             armed;
  logic [PIN_W-1:0] ref_q;
  logic             any_diff;

  pci_clear_qual u_qual (
    .dev_sel (dev_sel),
    .rd_ack  (rd_ack),
    .wr_ack  (wr_ack),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .clr_src (clr_src),
    .clr_evt (clr_evt)
  );

  pci_ref_store #(.PIN_W(PIN_W)) u_ref (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins   (pins),
    .clr_evt(clr_evt),
    .armed  (armed),
    .ref_q  (ref_q)
  );

  pci_diff #(.PIN_W(PIN_W), .GRP_W(GRP_W)) u_diff (
    .cur     (pins),
    .snap    (ref_q),
    .any_diff(any_diff)
  );

  pci_irq_out u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed   (armed),
    .clr_evt (clr_evt),
    .any_diff(any_diff),
    .int_n   (int_n)
  );
endmodule

// File: rtl/pci_checker.sv
module pci_checker #(
  parameter int PIN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PIN_W-1:0] pins,
  input logic             dev_sel,
  input logic             rd_ack,
  input logic             wr_ack,
  input logic             scl_rise,
  input logic             scl_fall,
  input logic             int_n,
  input logic             armed,
  input logic             clr_evt,
  input logic [PIN_W-1:0] ref_q
);
  AST_UNARMED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> int_n); // R1

  AST_CHANGE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !clr_evt && (pins != ref_q) |=> !int_n); // R2

  AST_REVERT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !clr_evt && (pins == ref_q) |=> int_n); // R3

  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    armed && dev_sel && rd_ack && scl_rise |=> int_n && (ref_q == $past(pins))); // R4

  AST_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    armed && dev_sel && wr_ack && scl_fall |=> int_n && (ref_q == $past(pins))); // R5

  AST_WRONG_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !(rd_ack && scl_rise) && !(wr_ack && scl_fall) |=> $stable(ref_q)); // R6

  AST_FOREIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !dev_sel |=> $stable(ref_q)); // R7

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_rise && scl_fall) && !(rd_ack && wr_ack)); // R6
endmodule

bind pin_change_irq pci_checker #(.PIN_W(PIN_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pins    (pins),
  .dev_sel (dev_sel),
  .rd_ack  (rd_ack),
  .wr_ack  (wr_ack),
  .scl_rise(scl_rise),
  .scl_fall(scl_fall),
  .int_n   (int_n),
  .armed   (armed),
  .clr_evt (clr_evt),
  .ref_q   (ref_q)
);

// File: tb/test_pin_change_irq.sv
module test_pin_change_irq;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pins = 16'hA5C3;
  logic         dev_sel = 1'b0, rd_ack = 1'b0, wr_ack = 1'b0;
  logic         scl_rise = 1'b0, scl_fall = 1'b0;
  wire          int_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = !clk;

  pin_change_irq #(.PIN_W(W)) i_pin_change_irq (
    .clk(clk), .rst_n(rst_n), .pins(pins), .dev_sel(dev_sel),
    .rd_ack(rd_ack), .wr_ack(wr_ack), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .int_n(int_n)
  );

  // Behavioural reference: one snapshot word and a request flag.
  logic [W-1:0] m_snap;
  bit           m_primed;
  bit           m_req;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_primed <= 1'b0;
      m_req    <= 1'b0;
      m_snap   <= '0;
    end else if (!m_primed) begin
      m_primed <= 1'b1;
      m_snap   <= pins;
    end else if (dev_sel && ((rd_ack && scl_rise) || (wr_ack && scl_fall))) begin
      m_snap <= pins;   // R4 R5 R9
      m_req  <= 1'b0;
    end else begin
      m_req <= (pins != m_snap);   // R2 R3 R8
    end
  end

  // Cycle compare against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_run++;
      if (int_n !== !m_req) begin
        n_fail++;
        $display("FAIL R2 R3 cycle compare: int_n=%0b expected %0b", int_n, !m_req);
      end
    end
  end

  task automatic chk(input logic got, input logic exp, input string tag);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: int_n=%0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One-cycle bus strobe; kind 0 read/rise, 1 write/fall, 2 read/fall, 3 write/rise
  task automatic strobe(input int kind, input logic sel);
    dev_sel  = sel;
    rd_ack   = (kind == 0 || kind == 2);
    wr_ack   = (kind == 1 || kind == 3);
    scl_rise = (kind == 0 || kind == 3);
    scl_fall = (kind == 1 || kind == 2);
    @(negedge clk);
    dev_sel = 1'b0; rd_ack = 1'b0; wr_ack = 1'b0;
    scl_rise = 1'b0; scl_fall = 1'b0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk(int_n, 1'b1, "R1 idle after reset");
    cyc(3);
    chk(int_n, 1'b1, "R1 non-zero pins raise nothing");

    pins[0] = !pins[0];
    cyc(1);
    chk(int_n, 1'b0, "R2 pin0 change");
    pins[0] = !pins[0];
    cyc(1);
    chk(int_n, 1'b1, "R3 revert releases");

    pins[15] = 1'b0;               // falling change on bit 15
    cyc(1);
    chk(int_n, 1'b0, "R2 falling change");
    pins[15] = 1'b1;
    cyc(1);
    chk(int_n, 1'b1, "R3 revert bit 15");

    for (int b = 0; b < W; b++) begin
      pins[b] = !pins[b];
      cyc(1);
      chk(int_n, 1'b0, "R2 single pin sweep");
      pins[b] = !pins[b];
      cyc(1);
    end

    pins = 16'h1234;
    cyc(2);
    chk(int_n, 1'b0, "R2 multi pin pattern");
    strobe(0, 1'b1);
    chk(int_n, 1'b1, "R4 read clear");
    cyc(2);
    chk(int_n, 1'b1, "R4 new reference held");

    pins = 16'hA5C3;
    cyc(1);
    chk(int_n, 1'b0, "R8 old value now a change");
    strobe(1, 1'b1);
    chk(int_n, 1'b1, "R5 write clear");
    cyc(2);
    chk(int_n, 1'b1, "R5 reference captured");

    pins = 16'h00FF;
    cyc(1);
    chk(int_n, 1'b0, "R8 change after write clear");
    strobe(2, 1'b1);
    chk(int_n, 1'b0, "R6 read ack on falling edge");
    strobe(3, 1'b1);
    chk(int_n, 1'b0, "R6 write ack on rising edge");
    strobe(0, 1'b0);
    chk(int_n, 1'b0, "R7 foreign read");
    strobe(1, 1'b0);
    chk(int_n, 1'b0, "R7 foreign write");
    pins = 16'hA5C3;
    cyc(1);
    chk(int_n, 1'b1, "R6 R7 reference untouched");

    pins = 16'h5A5A;               // change lands on the clear cycle
    strobe(0, 1'b1);
    chk(int_n, 1'b1, "R9 change absorbed by read clear");
    cyc(2);
    chk(int_n, 1'b1, "R9 no late request");
    pins = 16'h5A5B;
    strobe(1, 1'b1);
    chk(int_n, 1'b1, "R9 change absorbed by write clear");
    pins = 16'h5A5A;
    cyc(1);
    chk(int_n, 1'b0, "R8 against absorbed value");

    cyc(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule